// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit sits in the operand path of a 16-bit processor with segmented memory. It takes an addressing-mode pair that has already been decoded (a 2-bit mode field and a 3-bit register/memory field), the operand-width bit, a displacement, and the current values of the two base registers, the two index registers and the four segment registers. It forms the 16-bit offset of the operand. It picks the segment that qualifies that offset and produces the 20-bit physical address. When the mode field names a register operand, it reports the register index instead of an address.

A segment-override prefix byte can be presented on a separate strobe before the request, or in the same cycle as the request. The prefix is held by a two-state controller. `OVR_IDLE` means no override is pending. `OVR_ARMED` means an override is held for the next request. The controller has three transitions. From `OVR_IDLE` it moves to `OVR_ARMED` when a well-formed prefix is strobed without a request. It stays in `OVR_ARMED` when a new prefix arrives, and the new segment code replaces the held one. It returns from `OVR_ARMED` to `OVR_IDLE` when a request is accepted. A prefix strobed in the same cycle as a request applies to that request directly, and the controller stays in `OVR_IDLE`. Results are registered: a request accepted on one clock edge is presented with a valid flag for exactly the following cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `req_valid` was high and low otherwise. Reset clears `out_valid`, `ea`, `phys`, `seg_sel`, `reg_mode`, `reg_idx` and `disp_len` to zero.
- R2: With mode 00 and a register/memory field other than 110, no displacement is used and `disp_len` is 0.
- R3: With mode 00 and register/memory field 110, `ea` equals the 16-bit displacement with no base or index added, `disp_len` is 2, and the default segment is DS.
- R4: Mode 01 adds the low displacement byte sign-extended to 16 bits (the upper displacement byte is ignored), and `disp_len` is 1.
- R5: Mode 10 adds the full 16-bit displacement, and `disp_len` is 2.
- R6: The register/memory field selects the base/index sum: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP (direct address when mode is 00), 111 BX.
- R7: `seg_sel` is encoded 00 ES, 01 CS, 10 SS, 11 DS. Without an override, a memory operand that uses BP selects SS, and every other memory operand selects DS.
- R8: A byte of the form 001ss110 strobed with `pfx_valid` selects segment code ss for the next accepted request only. This holds whether the strobe comes in an earlier cycle or in the request's own cycle. A later strobe replaces a pending one. After that request, the default rule applies again.
- R9: A byte strobed with `pfx_valid` that does not have the form 001ss110 has no effect. A well-formed byte presented without `pfx_valid` also has no effect.
- R10: `phys` equals the selected segment value shifted left by four bits plus `ea`, taken modulo 2^20.
- R11: With mode 11, `reg_mode` is 1 and `reg_idx` is {W, field}. Indices 0–7 are AL, CL, DL, BL, AH, CH, DH, BH, and indices 8–15 are AX, CX, DX, BX, SP, BP, SI, DI. In this mode `ea`, `phys` and `disp_len` are 0 and `seg_sel` is DS. The request still consumes any pending override.
- R12: The offset sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Address request strobe |
| mod_f | input | 2 | Mode field |
| rm_f | input | 3 | Register/memory field |
| wide | input | 1 | Operand width bit (1 = 16-bit) |
| disp | input | 16 | Displacement (low byte only in mode 01) |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| pfx_valid | input | 1 | Prefix byte strobe |
| pfx_byte | input | 8 | Candidate override prefix byte |
| out_valid | output | 1 | Result valid |
| ea | output | 16 | Effective address |
| seg_sel | output | 2 | Selected segment code |
| phys | output | 20 | Physical address |
| reg_mode | output | 1 | Operand is a register |
| reg_idx | output | 4 | Register index {W, field} |
| disp_len | output | 2 | Displacement length in bytes |

## Verification
The hardest condition to reach is a pending override meeting each request shape. An override must be armed in an earlier cycle or strobed in the request's own cycle, then must vanish for the following request. A register-mode request must silently consume it. The bench sweeps every mode, field and width under every override choice and alternates how the prefix arrives. It then follows chosen requests with a plain request to show the override is gone. Register and displacement sets with negative low bytes and near-full offsets drive the sign-extension and wrap paths in both adders.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_code_t;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_DISP8  = 2'b01;
    localparam logic [1:0] MODE_DISP16 = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;

    localparam logic [2:0] RM_DIRECT   = 3'b110;

    localparam logic [2:0] PFX_TOP     = 3'b001;
    localparam logic [2:0] PFX_BOTTOM  = 3'b110;

    typedef struct packed {
        logic       use_bx;
        logic       use_bp;
        logic       use_si;
        logic       use_di;
        logic       direct;
        logic       reg_op;
        logic       add_d8;
        logic       add_d16;
        logic [1:0] disp_len;
    } addr_plan_t;

    function automatic logic is_seg_prefix(input logic [7:0] b);
        return (b[7:5] == PFX_TOP) && (b[2:0] == PFX_BOTTOM);
    endfunction

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
    import seg_addr_pkg::*;
(
    input  logic [1:0]  mod_f,
    input  logic [2:0]  rm_f,
    output addr_plan_t  plan
);

    logic bx_on, bp_on, si_on, di_on;

    // base/index pairing by field value
    always_comb begin
        bx_on = 1'b0;
        bp_on = 1'b0;
        si_on = 1'b0;
        di_on = 1'b0;
        unique case (rm_f)
            3'b000: begin bx_on = 1'b1; si_on = 1'b1; end
            3'b001: begin bx_on = 1'b1; di_on = 1'b1; end
            3'b010: begin bp_on = 1'b1; si_on = 1'b1; end
            3'b011: begin bp_on = 1'b1; di_on = 1'b1; end
            3'b100: si_on = 1'b1;
            3'b101: di_on = 1'b1;
            3'b110: bp_on = 1'b1;
            3'b111: bx_on = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        plan = '0;
        unique case (mod_f)
            MODE_NODISP: begin
                if (rm_f == RM_DIRECT) begin
                    plan.direct   = 1'b1;
                    plan.add_d16  = 1'b1;
                    plan.disp_len = 2'd2;
                end else begin
                    plan.use_bx = bx_on;
                    plan.use_bp = bp_on;
                    plan.use_si = si_on;
                    plan.use_di = di_on;
                end
            end
            MODE_DISP8: begin
                plan.use_bx   = bx_on;
                plan.use_bp   = bp_on;
                plan.use_si   = si_on;
                plan.use_di   = di_on;
                plan.add_d8   = 1'b1;
                plan.disp_len = 2'd1;
            end
            MODE_DISP16: begin
                plan.use_bx   = bx_on;
                plan.use_bp   = bp_on;
                plan.use_si   = si_on;
                plan.use_di   = di_on;
                plan.add_d16  = 1'b1;
                plan.disp_len = 2'd2;
            end
            MODE_REG: begin
                plan.reg_op = 1'b1;
            end
            default: ;
        endcase
    end

    // R2/R3: only the direct case may carry a displacement in mode 00
    always_comb begin
        if (mod_f == MODE_NODISP && rm_f != RM_DIRECT)
            a_r2_no_disp: assert (!plan.add_d8 && !plan.add_d16);
    end

endmodule

// File: rtl/eag_offset_sum.sv
module eag_offset_sum
    import seg_addr_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  addr_plan_t         plan,
    input  logic [OFS_W-1:0]   disp,
    input  logic [OFS_W-1:0]   reg_bx,
    input  logic [OFS_W-1:0]   reg_bp,
    input  logic [OFS_W-1:0]   reg_si,
    input  logic [OFS_W-1:0]   reg_di,
    output logic [OFS_W-1:0]   ea
);

    localparam int EXT_W = OFS_W - BYTE_W;

    logic [OFS_W-1:0] base_term;
    logic [OFS_W-1:0] index_term;
    logic [OFS_W-1:0] disp_term;
    logic [OFS_W-1:0] d8_ext;

    assign d8_ext = {{EXT_W{disp[BYTE_W-1]}}, disp[BYTE_W-1:0]};

    always_comb begin
        base_term = '0;
        if (plan.use_bx) base_term = reg_bx;
        else if (plan.use_bp) base_term = reg_bp;
    end

    always_comb begin
        index_term = '0;
        if (plan.use_si) index_term = reg_si;
        else if (plan.use_di) index_term = reg_di;
    end

    always_comb begin
        disp_term = '0;
        if (plan.add_d16) disp_term = disp;
        else if (plan.add_d8) disp_term = d8_ext;
    end

    // modulo 2^OFS_W by truncation
    assign ea = plan.reg_op ? '0 : (base_term + index_term + disp_term);

    always_comb begin
        if (plan.direct)
            a_r3_direct_is_disp: assert (ea == disp);
    end

endmodule

// File: rtl/eag_seg_select.sv
module eag_seg_select
    import seg_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        pfx_valid,
    input  logic [7:0]  pfx_byte,
    input  addr_plan_t  plan,
    output seg_code_t   seg_sel,
    output logic        ovr_active
);

    typedef enum logic {
        OVR_IDLE  = 1'b0,
        OVR_ARMED = 1'b1
    } ovr_state_t;

    ovr_state_t state_q, state_d;
    seg_code_t  held_q;
    seg_code_t  use_code;
    logic       pfx_take;

    assign pfx_take = pfx_valid && is_seg_prefix(pfx_byte);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OVR_IDLE;
            held_q  <= SEG_ES;
        end else begin
            state_q <= state_d;
            if (pfx_take)
                held_q <= seg_code_t'(pfx_byte[4:3]);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_IDLE:  if (pfx_take && !req_valid) state_d = OVR_ARMED;
            OVR_ARMED: if (req_valid)              state_d = OVR_IDLE;
            default:                               state_d = OVR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        use_code   = held_q;
        ovr_active = 1'b0;
        unique case (state_q)
            OVR_IDLE: begin
                ovr_active = pfx_take;
                use_code   = seg_code_t'(pfx_byte[4:3]);
            end
            OVR_ARMED: begin
                ovr_active = 1'b1;
                use_code   = pfx_take ? seg_code_t'(pfx_byte[4:3]) : held_q;
            end
            default: ;
        endcase
        if (plan.reg_op)
            seg_sel = SEG_DS;
        else if (ovr_active)
            seg_sel = use_code;
        else if (plan.use_bp)
            seg_sel = SEG_SS;
        else
            seg_sel = SEG_DS;
    end

    // R8: an override never outlives the request that used it
    a_r8_override_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> state_q == OVR_IDLE);

    // R9: malformed prefix does not arm the controller
    a_r9_bad_prefix_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && !is_seg_prefix(pfx_byte) && state_q == OVR_IDLE) |=> state_q == OVR_IDLE);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                mod_f,
    input  logic [2:0]                rm_f,
    input  logic                      wide,
    input  logic [OFS_W-1:0]          disp,
    input  logic [OFS_W-1:0]          reg_bx,
    input  logic [OFS_W-1:0]          reg_bp,
    input  logic [OFS_W-1:0]          reg_si,
    input  logic [OFS_W-1:0]          reg_di,
    input  logic [OFS_W-1:0]          seg_es,
    input  logic [OFS_W-1:0]          seg_cs,
    input  logic [OFS_W-1:0]          seg_ss,
    input  logic [OFS_W-1:0]          seg_ds,
    input  logic                      pfx_valid,
    input  logic [7:0]                pfx_byte,
    output logic                      out_valid,
    output logic [OFS_W-1:0]          ea,
    output logic [1:0]                seg_sel,
    output logic [OFS_W+SEG_SHIFT-1:0] phys,
    output logic                      reg_mode,
    output logic [3:0]                reg_idx,
    output logic [1:0]                disp_len
);

    localparam int PA_W = OFS_W + SEG_SHIFT;

    addr_plan_t        plan;
    logic [OFS_W-1:0]  ea_c;
    seg_code_t         seg_c;
    logic              ovr_active;
    logic [OFS_W-1:0]  seg_val;
    logic [PA_W-1:0]   phys_c;

    eag_mode_decode u_decode (
        .mod_f (mod_f),
        .rm_f  (rm_f),
        .plan  (plan)
    );

    eag_offset_sum #(.OFS_W(OFS_W)) u_sum (
        .plan   (plan),
        .disp   (disp),
        .reg_bx (reg_bx),
        .reg_bp (reg_bp),
        .reg_si (reg_si),
        .reg_di (reg_di),
        .ea     (ea_c)
    );

    eag_seg_select u_seg (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .pfx_valid  (pfx_valid),
        .pfx_byte   (pfx_byte),
        .plan       (plan),
        .seg_sel    (seg_c),
        .ovr_active (ovr_active)
    );

    always_comb begin
        unique case (seg_c)
            SEG_ES:  seg_val = seg_es;
            SEG_CS:  seg_val = seg_cs;
            SEG_SS:  seg_val = seg_ss;
            SEG_DS:  seg_val = seg_ds;
            default: seg_val = seg_ds;
        endcase
    end

    assign phys_c = plan.reg_op ? '0
                  : ({seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_c});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ea        <= '0;
            seg_sel   <= '0;
            phys      <= '0;
            reg_mode  <= 1'b0;
            reg_idx   <= '0;
            disp_len  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                ea       <= ea_c;
                seg_sel  <= seg_c;
                phys     <= phys_c;
                reg_mode <= plan.reg_op;
                reg_idx  <= plan.reg_op ? {wide, rm_f} : 4'd0;
                disp_len <= plan.disp_len;
            end
        end
    end

    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    a_r11_reg_no_address: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && reg_mode) |-> (ea == '0 && phys == '0 && disp_len == 2'd0));

    a_r7_bp_defaults_to_ss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_active && mod_f != MODE_REG &&
         (rm_f == 3'b010 || rm_f == 3'b011 || (rm_f == RM_DIRECT && mod_f != MODE_NODISP)))
        |=> seg_sel == SEG_SS);

    a_r10_phys_from_segment: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !reg_mode) |->
        phys == ({(seg_sel == SEG_ES) ? $past(seg_es) :
                  (seg_sel == SEG_CS) ? $past(seg_cs) :
                  (seg_sel == SEG_SS) ? $past(seg_ss) : $past(seg_ds),
                  {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea}));

    a_r4_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> disp_len != 2'd3);

endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  mod_f = '0;
    logic [2:0]  rm_f = '0;
    logic        wide = 1'b0;
    logic [15:0] disp = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic        pfx_valid = 1'b0;
    logic [7:0]  pfx_byte = '0;
    logic        out_valid;
    logic [15:0] ea;
    logic [1:0]  seg_sel;
    logic [19:0] phys;
    logic        reg_mode;
    logic [3:0]  reg_idx;
    logic [1:0]  disp_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mod_f(mod_f), .rm_f(rm_f),
        .wide(wide), .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
        .reg_di(reg_di), .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .pfx_valid(pfx_valid), .pfx_byte(pfx_byte), .out_valid(out_valid), .ea(ea),
        .seg_sel(seg_sel), .phys(phys), .reg_mode(reg_mode), .reg_idx(reg_idx),
        .disp_len(disp_len)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ea(input logic [1:0] m, input logic [2:0] r,
                                           input logic [15:0] d);
        logic [15:0] s;
        if (m == 2'b11) return 16'h0;
        if (m == 2'b00 && r == 3'b110) return d;
        case (r)
            3'd0: s = reg_bx + reg_si;
            3'd1: s = reg_bx + reg_di;
            3'd2: s = reg_bp + reg_si;
            3'd3: s = reg_bp + reg_di;
            3'd4: s = reg_si;
            3'd5: s = reg_di;
            3'd6: s = reg_bp;
            default: s = reg_bx;
        endcase
        if (m == 2'b01) s = s + {{8{d[7]}}, d[7:0]};
        if (m == 2'b10) s = s + d;
        return s;
    endfunction

    function automatic logic [1:0] exp_seg(input logic [1:0] m, input logic [2:0] r,
                                           input bit ovr, input logic [1:0] sr);
        if (m == 2'b11) return 2'b11;
        if (ovr) return sr;
        if (r == 3'd2 || r == 3'd3 || (r == 3'd6 && m != 2'b00)) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [1:0] exp_len(input logic [1:0] m, input logic [2:0] r);
        case (m)
            2'b00: return (r == 3'b110) ? 2'd2 : 2'd0;
            2'b01: return 2'd1;
            2'b10: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [15:0] seg_value(input logic [1:0] c);
        case (c)
            2'b00: return seg_es;
            2'b01: return seg_cs;
            2'b10: return seg_ss;
            default: return seg_ds;
        endcase
    endfunction

    task automatic send_pfx(input logic v, input logic [7:0] b);
        @(negedge clk);
        pfx_valid = v;
        pfx_byte  = b;
        @(negedge clk);
        pfx_valid = 1'b0;
    endtask

    task automatic issue(input logic [1:0] m, input logic [2:0] r, input logic w,
                         input logic [15:0] d, input logic pv, input logic [7:0] pb);
        @(negedge clk);
        req_valid = 1'b1;
        mod_f = m; rm_f = r; wide = w; disp = d;
        pfx_valid = pv; pfx_byte = pb;
        @(negedge clk);
        req_valid = 1'b0;
        pfx_valid = 1'b0;
    endtask

    task automatic verify(input logic [1:0] m, input logic [2:0] r, input logic w,
                          input logic [15:0] d, input bit ovr, input logic [1:0] sr);
        string t;
        logic [15:0] e;
        logic [1:0]  s;
        logic [19:0] p;
        e = exp_ea(m, r, d);
        s = exp_seg(m, r, ovr, sr);
        p = (m == 2'b11) ? 20'h0 : ({seg_value(s), 4'h0} + {4'h0, e});
        if (m == 2'b11) t = "R11";
        else if (m == 2'b00 && r == 3'b110) t = "R3";
        else if (m == 2'b00) t = "R2_R6";
        else if (m == 2'b01) t = "R4_R6";
        else t = "R5_R6";
        chk("R1 out_valid", {31'b0, out_valid}, 32'd1);
        chk({t, " ea"}, {16'b0, ea}, {16'b0, e});
        chk({t, " disp_len"}, {30'b0, disp_len}, {30'b0, exp_len(m, r)});
        chk(ovr ? "R8 seg_sel" : "R7 seg_sel", {30'b0, seg_sel}, {30'b0, s});
        chk("R10 phys", {12'b0, phys}, {12'b0, p});
        chk("R11 reg_mode", {31'b0, reg_mode}, {31'b0, (m == 2'b11)});
        chk("R11 reg_idx", {28'b0, reg_idx}, (m == 2'b11) ? {28'b0, w, r} : 32'd0);
    endtask

    task automatic load_set(input int k);
        case (k)
            0: begin reg_bx = 16'h0200; reg_bp = 16'h1100; reg_si = 16'h1000; reg_di = 16'h0020;
                     seg_es = 16'h4000; seg_cs = 16'h1234; seg_ss = 16'h5000; seg_ds = 16'h3000; end
            1: begin reg_bx = 16'hFFF0; reg_bp = 16'hFF00; reg_si = 16'h0030; reg_di = 16'h01FF;
                     seg_es = 16'hFFFF; seg_cs = 16'h8000; seg_ss = 16'hF000; seg_ds = 16'hFFF8; end
            default: begin reg_bx = 16'h0007; reg_bp = 16'h0003; reg_si = 16'h8001; reg_di = 16'h7FFF;
                     seg_es = 16'h0001; seg_cs = 16'h0000; seg_ss = 16'hABCD; seg_ds = 16'h0FFF; end
        endcase
    endtask

    function automatic logic [15:0] disp_for(input int k);
        case (k)
            0: return 16'h5A9C;
            1: return 16'h0071;
            default: return 16'h8001;
        endcase
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        load_set(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 reset ea", {16'b0, ea}, 32'd0);
        chk("R1 reset phys", {12'b0, phys}, 32'd0);
        chk("R1 reset seg_sel", {30'b0, seg_sel}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: register sets x override choice x mode x field x width
        for (int k = 0; k < 3; k++) begin
            load_set(k);
            for (int o = 0; o < 5; o++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int r = 0; r < 8; r++) begin
                        for (int w = 0; w < 2; w++) begin
                            logic [7:0] pb;
                            pb = {3'b001, 2'(o - 1), 3'b110};
                            if (o != 0 && w == 0) begin
                                send_pfx(1'b1, pb);
                                issue(2'(m), 3'(r), 1'(w), disp_for(k), 1'b0, 8'h00);
                            end else begin
                                issue(2'(m), 3'(r), 1'(w), disp_for(k), (o != 0), pb);
                            end
                            verify(2'(m), 3'(r), 1'(w), disp_for(k), (o != 0), 2'(o - 1));
                        end
                    end
                end
            end
        end

        // R10 worked value: DS=3000 BX=0200 SI=1000 disp 08 -> 31208
        load_set(0);
        issue(2'b01, 3'b000, 1'b0, 16'h0008, 1'b0, 8'h00);
        chk("R10 example phys", {12'b0, phys}, 32'h31208);

        // R1 valid drops the cycle after a lone request
        @(negedge clk);
        chk("R1 valid drop", {31'b0, out_valid}, 32'd0);

        // R8 override used once, then default returns
        send_pfx(1'b1, 8'h26);
        issue(2'b00, 3'b111, 1'b1, 16'h0, 1'b0, 8'h00);
        chk("R8 override applied", {30'b0, seg_sel}, 32'd0);
        issue(2'b00, 3'b111, 1'b1, 16'h0, 1'b0, 8'h00);
        chk("R8 override cleared", {30'b0, seg_sel}, 32'd3);

        // R8 later prefix replaces pending one
        send_pfx(1'b1, 8'h26);
        send_pfx(1'b1, 8'h2E);
        issue(2'b00, 3'b111, 1'b1, 16'h0, 1'b0, 8'h00);
        chk("R8 replaced override", {30'b0, seg_sel}, 32'd1);

        // R9 malformed prefix with strobe, good byte without strobe
        send_pfx(1'b1, 8'h3F);
        issue(2'b10, 3'b010, 1'b1, 16'h0004, 1'b0, 8'h00);
        chk("R9 bad prefix ignored", {30'b0, seg_sel}, 32'd2);
        send_pfx(1'b0, 8'h26);
        issue(2'b00, 3'b100, 1'b1, 16'h0, 1'b0, 8'h26);
        chk("R9 unstrobed prefix ignored", {30'b0, seg_sel}, 32'd3);

        // R11 register request consumes a pending override
        send_pfx(1'b1, 8'h36);
        issue(2'b11, 3'b101, 1'b1, 16'h0, 1'b0, 8'h00);
        chk("R11 reg idx BP", {28'b0, reg_idx}, 32'd13);
        issue(2'b00, 3'b111, 1'b0, 16'h0, 1'b0, 8'h00);
        chk("R11 override consumed", {30'b0, seg_sel}, 32'd3);

        // R4 sign extension and R12 wrap
        reg_bx = 16'h0100;
        issue(2'b01, 3'b111, 1'b0, 16'h7F80, 1'b0, 8'h00);
        chk("R4 sign extended disp", {16'b0, ea}, 32'h0080);
        reg_bx = 16'hFFFF; reg_si = 16'h0002;
        issue(2'b10, 3'b000, 1'b0, 16'hFFFF, 1'b0, 8'h00);
        chk("R12 offset wrap", {16'b0, ea}, 32'h0000);
        seg_ds = 16'hFFFF;
        issue(2'b00, 3'b110, 1'b0, 16'h0020, 1'b0, 8'h00);
        chk("R10 physical wrap", {12'b0, phys}, 32'h00010);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule